// File: doc/BRIEF.md
# Header Field Modifier

This block rewrites one 16-bit field of each outgoing packet header so that a single traffic stream becomes many distinct flows. It keeps a current value and an up-to-date repetition count. At each packet boundary the packet engine pulses an advance strobe. The block then either holds the value for another packet or moves it to the next value in the programmed sequence.

The sequence can run in three modes: it can increment or decrement by a programmable stride, or it can draw pseudo-random values. In every mode the values stay between a programmed lower and upper bound. A bit-mask chooses which bits of the field are replaced. The other bits pass through from the original header unchanged. A stream that needs two rewritten fields instantiates the block twice, and each instance gets its own configuration.

Locating the field in the frame and recomputing checksums are left to neighbouring logic. The block only sees the original field value and returns the modified one.

Top module: `hdr_field_mod`

## Requirements
- R1: `field_out` is `(field_in & ~cfg_mask) | (value & cfg_mask)` in the same cycle, where `value` is the current sequence value.
- R2: A synchronous reset (`rst_n` low) or a `restart` pulse sets the value to `cfg_min`, or to `cfg_max` in decrement mode. It also clears the repetition count and reseeds the random generator. `restart` takes priority over `advance` in the same cycle.
- R3: Each value is kept for exactly `cfg_reps + 1` advance pulses before the next value appears.
- R4: In increment mode (`cfg_mode` = 2'b00) the next value is `value + cfg_step`. If that sum, taken as a 17-bit number, exceeds `cfg_max`, the next value is `cfg_min` instead.
- R5: In decrement mode (`cfg_mode` = 2'b01) the next value is `value - cfg_step`. If `value < cfg_min + cfg_step`, the next value is `cfg_max` instead.
- R6: In random mode (`cfg_mode` = 2'b10 or 2'b11) a 16-bit generator is used. It is seeded with 16'hACE1 and shifts left, taking in the new bit `g[15]^g[13]^g[12]^g[10]`, once per value change. Let `s = cfg_max - cfg_min`, and let `f` be the smallest all-ones mask that is at least `s`. The new value is `cfg_min + r`, where `r = g & f`, minus `s + 1` when that exceeds `s`. Here `g` is the shifted generator state.
- R7: Without `advance` or `restart`, the value and repetition count do not change, whatever the other inputs do.
- R8: When `cfg_min <= cfg_max` and the current value lies within that window, every value change keeps it within the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 00 increment, 01 decrement, 1x random |
| cfg_min | input | 16 | Lower bound of the value window |
| cfg_max | input | 16 | Upper bound of the value window |
| cfg_step | input | 16 | Stride for increment and decrement |
| cfg_reps | input | REP_W | Extra packets each value is held for |
| cfg_mask | input | 16 | 1 = bit replaced by the generated value |
| restart | input | 1 | Reload the start value and clear the count |
| advance | input | 1 | One pulse per packet that used the field |
| field_in | input | 16 | Original header field |
| field_out | output | 16 | Modified header field |

## Verification
A corrupted value register shows on the very next packet's masked bits, because the merge is combinational. A wrong repetition count instead shows only at the end of a hold period, when a value changes one packet early or late. The bench therefore steps through whole hold periods and compares every packet, not just the values at change points. A generator that is out of step stays hidden while it lands in the same folded value, so random mode is compared over a long run of packets against an independent model.

// File: rtl/hdr_field_mod.sv
module hdr_field_mod #(
  parameter int          REP_W = 16,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [15:0]      cfg_min,
  input  logic [15:0]      cfg_max,
  input  logic [15:0]      cfg_step,
  input  logic [REP_W-1:0] cfg_reps,
  input  logic [15:0]      cfg_mask,
  input  logic             restart,
  input  logic             advance,
  input  logic [15:0]      field_in,
  output logic [15:0]      field_out
);

  logic [15:0]      cur, lfsr;
  logic [REP_W-1:0] rep;

  wire is_dec  = (cfg_mode == 2'b01);
  wire is_rnd  = cfg_mode[1];
  wire rep_hit = (rep >= cfg_reps);

  wire [16:0] up_sum   = {1'b0, cur} + {1'b0, cfg_step};
  wire [16:0] dn_floor = {1'b0, cfg_min} + {1'b0, cfg_step};
  wire [15:0] inc_val  = (up_sum > {1'b0, cfg_max}) ? cfg_min : up_sum[15:0];
  wire [15:0] dec_val  = ({1'b0, cur} < dn_floor) ? cfg_max : cur - cfg_step;

  wire [15:0] lfsr_nx = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  wire [15:0] span    = cfg_max - cfg_min;
  wire [15:0] f1      = span | (span >> 1);
  wire [15:0] f2      = f1 | (f1 >> 2);
  wire [15:0] f4      = f2 | (f2 >> 4);
  wire [15:0] fill    = f4 | (f4 >> 8);
  wire [15:0] raw     = lfsr_nx & fill;
  wire [15:0] folded  = (raw > span) ? raw - span - 16'd1 : raw;
  wire [15:0] rnd_val = cfg_min + folded;

  wire [15:0] next_val = is_rnd ? rnd_val : (is_dec ? dec_val : inc_val);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cur  <= is_dec ? cfg_max : cfg_min;
      rep  <= '0;
      lfsr <= SEED;
    end else if (advance) begin
      if (rep_hit) begin
        rep <= '0;
        cur <= next_val;
        if (is_rnd) lfsr <= lfsr_nx;
      end else begin
        rep <= rep + 1'b1;
      end
    end
  end

  assign field_out = (field_in & ~cfg_mask) | (cur & cfg_mask);

  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cur == ($past(cfg_mode) == 2'b01 ? $past(cfg_max) : $past(cfg_min))) && (rep == '0)); // R2

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && !rep_hit) |=> $stable(cur)); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> ($stable(cur) && $stable(rep))); // R7

  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && rep_hit && cfg_min <= cfg_max && cur >= cfg_min && cur <= cfg_max)
      |=> (cur >= $past(cfg_min) && cur <= $past(cfg_max))); // R8

endmodule

// File: tb/tb_hdr_field_mod.sv
module tb_hdr_field_mod;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'b00;
  logic [15:0] cfg_min = 16'd10, cfg_max = 16'd20, cfg_step = 16'd3;
  logic [15:0] cfg_reps = 16'd0, cfg_mask = 16'hFFFF;
  logic        restart = 1'b0, advance = 1'b0;
  logic [15:0] field_in = 16'h0000;
  logic [15:0] field_out;

  int checks = 0, errors = 0;
  logic [15:0] m_cur, m_lfsr;
  int          m_rep;

  always #5 clk = ~clk;

  hdr_field_mod #(.REP_W(16), .SEED(16'hACE1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_min(cfg_min),
    .cfg_max(cfg_max), .cfg_step(cfg_step), .cfg_reps(cfg_reps),
    .cfg_mask(cfg_mask), .restart(restart), .advance(advance),
    .field_in(field_in), .field_out(field_out));

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rnd_pick(logic [15:0] g, logic [15:0] lo, logic [15:0] hi);
    logic [15:0] s, f, r;
    s = hi - lo;
    f = 16'h0;
    while (f < s) f = (f << 1) | 16'h1;
    r = g & f;
    if (r > s) r = r - s - 16'd1;
    return lo + r;
  endfunction

  task automatic model_load();
    m_cur  = (cfg_mode == 2'b01) ? cfg_max : cfg_min;
    m_rep  = 0;
    m_lfsr = 16'hACE1;
  endtask

  task automatic model_adv();
    if (m_rep >= int'(cfg_reps)) begin
      m_rep = 0;
      if (cfg_mode[1]) begin
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        m_cur  = rnd_pick(m_lfsr, cfg_min, cfg_max);
      end else if (cfg_mode == 2'b01) begin
        if (17'(m_cur) < 17'(cfg_min) + 17'(cfg_step)) m_cur = cfg_max;
        else m_cur = m_cur - cfg_step;
      end else begin
        if (17'(m_cur) + 17'(cfg_step) > 17'(cfg_max)) m_cur = cfg_min;
        else m_cur = m_cur + cfg_step;
      end
    end else m_rep++;
  endtask

  task automatic do_restart();
    @(negedge clk) restart = 1'b1;
    model_load();
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic do_adv();
    @(negedge clk) advance = 1'b1;
    model_adv();
    @(negedge clk) advance = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_load();
    @(negedge clk);
    check16("R2 reset loads min", field_out, 16'd10);
  endtask

  task automatic t_merge();
    cfg_mask = 16'h0F0F; field_in = 16'hA5A5;
    #1 check16("R1 partial mask", field_out, 16'hA0AA);
    cfg_mask = 16'h0000; field_in = 16'h1234;
    #1 check16("R1 empty mask", field_out, 16'h1234);
    cfg_mask = 16'hFFFF; field_in = 16'h0000;
    #1 check16("R1 full mask", field_out, m_cur);
  endtask

  task automatic t_inc();
    cfg_mode = 2'b00; cfg_min = 16'd10; cfg_max = 16'd20; cfg_step = 16'd3; cfg_reps = 16'd0;
    do_restart();
    for (int i = 0; i < 7; i++) begin
      do_adv();
      check16("R4 increment", field_out, m_cur);
    end
    cfg_min = 16'hFFF0; cfg_max = 16'hFFFF; cfg_step = 16'h0009;
    do_restart();
    do_adv(); check16("R4 near top", field_out, 16'hFFF9);
    do_adv(); check16("R4 17-bit wrap", field_out, 16'hFFF0);
  endtask

  task automatic t_dec();
    cfg_mode = 2'b01; cfg_min = 16'd5; cfg_max = 16'd30; cfg_step = 16'd7; cfg_reps = 16'd0;
    do_restart();
    check16("R2 restart loads max in decrement", field_out, 16'd30);
    for (int i = 0; i < 6; i++) begin
      do_adv();
      check16("R5 decrement", field_out, m_cur);
    end
  endtask

  task automatic t_repeat();
    cfg_mode = 2'b00; cfg_min = 16'd0; cfg_max = 16'd100; cfg_step = 16'd1; cfg_reps = 16'd2;
    do_restart();
    for (int i = 0; i < 9; i++) begin
      do_adv();
      check16("R3 repetition", field_out, 16'((i + 1) / 3));
    end
  endtask

  task automatic t_random();
    cfg_mode = 2'b10; cfg_min = 16'd100; cfg_max = 16'd1100; cfg_reps = 16'd0;
    do_restart();
    for (int i = 0; i < 40; i++) begin
      do_adv();
      check16("R6 random value", field_out, m_cur);
      checks++;
      if (field_out < 16'd100 || field_out > 16'd1100) begin
        errors++;
        $display("FAIL R8 window: actual %h expected 0064..044C", field_out);
      end
    end
    cfg_mode = 2'b11; cfg_min = 16'd0; cfg_max = 16'hFFFF; cfg_reps = 16'd1;
    do_restart();
    for (int i = 0; i < 10; i++) begin
      do_adv();
      check16("R6 random full range", field_out, m_cur);
    end
  endtask

  task automatic t_idle_and_priority();
    cfg_mode = 2'b00; cfg_min = 16'd40; cfg_max = 16'd90; cfg_step = 16'd5; cfg_reps = 16'd0;
    do_restart();
    do_adv(); do_adv();
    check16("R4 before idle", field_out, 16'd50);
    @(negedge clk) cfg_step = 16'd1; field_in = 16'hFFFF;
    repeat (5) @(negedge clk);
    check16("R7 idle holds value", field_out, 16'd50);
    cfg_step = 16'd5; field_in = 16'h0000;
    @(negedge clk) begin restart = 1'b1; advance = 1'b1; end
    model_load();
    @(negedge clk) begin restart = 1'b0; advance = 1'b0; end
    check16("R2 restart beats advance", field_out, 16'd40);
    do_adv();
    check16("R2 count cleared by restart", field_out, 16'd45);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_merge();
    t_inc();
    t_dec();
    t_repeat();
    t_random();
    t_idle_and_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule